// File: doc/BRIEF.md
# Health-Gated Loop Supervisor

This block watches a local control loop and decides whether its software is trustworthy enough to keep driving the actuator. A windowed watchdog accepts a service feed only when the period since the last accepted feed contains positive evidence of health: a heartbeat, at least one sampling strobe, at least one output-update strobe, and no deadline miss. A feed that arrives too soon, never arrives before the window closes, or arrives without that evidence is treated as a fault.

Faults drive a small manager that asks the output stage for its safe value while it waits out a backoff interval and then retries. Each fault that happens before the next accepted feed raises a retry count; once that count is used up, the next fault latches the block until a service clear. A degrade request keeps the loop running with reduced limits. Two supply comparator inputs are handled separately: the higher warning threshold moves the block to a safe wait, and the lower threshold asserts a reset request and wins over everything else.

Every event writes one record in a single cycle: a sequence number that only counts up, a timestamp taken from a free-running cycle counter, and a cause code, with a one-cycle commit flag marking the new record. The record is a register, not a stream: it carries no back-pressure and a later event simply overwrites it, so a consumer copies it on the commit cycle. Deadline-miss and heartbeat-miss counters can be read at any time.

Top module: `loop_supervisor`

## Requirements
- R1: A feed while the window count is at least WIN_OPEN and below WIN_CLOSE, with a heartbeat, a sampling strobe and an update strobe seen and no deadline miss since the window opened (the feed cycle included), is accepted: no event is logged, the state is unchanged and the window restarts at zero.
- R2: A feed while the window count is below WIN_OPEN is an early fault with cause code 1.
- R3: When the window count reaches WIN_CLOSE without an accepted feed, a late fault with cause code 2 is raised.
- R4: A feed inside the window that lacks any of the health evidence of R1 is an unhealthy fault with cause code 3; an external fault pulse raises cause code 4.
- R5: State codes are 0 run, 1 degraded, 2 backoff, 3 latched, 4 warning, 5 reset. A recoverable fault in run or degraded enters backoff for exactly BACKOFF_CYC cycles with safe_req high and the retry count raised by one; faults arriving during backoff are ignored; backoff then returns to run, or to degraded if degraded mode is held.
- R6: A fault while the retry count equals MAX_RETRY enters the latched state with cause code 5; only a service clear leaves it (to run, cause code 9, retry count zero); faults and the warning input have no effect there.
- R7: A degrade request in run enters the degraded state with cause code 6 and raises degraded, with safe_req low; the watchdog keeps running; degraded mode ends only through a service clear or a brownout reset.
- R8: The warning input (outside the latched state) enters the warning state with cause code 7 and safe_req high; one record is written on entry only; when it falls the block enters backoff without changing the retry count.
- R9: The reset input has top priority: the next cycle is in the reset state with sys_reset high, cause code 8 is logged on entry, the retry count and degraded mode are cleared, and release leads to backoff.
- R10: Each event writes cause, timestamp and a sequence number one above the previous one (holding at its maximum value, never wrapping) in the same clock edge, and the commit flag is high for exactly the cycle after that edge; timestamps of successive records strictly increase.
- R11: The deadline-miss counter counts every deadline-miss pulse and the heartbeat-miss counter counts every window end (accepted, early, late or unhealthy) without a heartbeat; both saturate.
- R12: An accepted feed clears the retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| heartbeat_i | input | 1 | Software heartbeat pulse |
| deadline_miss_i | input | 1 | Control-deadline miss pulse |
| sample_stb_i | input | 1 | Sampling strobe observed |
| update_stb_i | input | 1 | Output update strobe observed |
| feed_i | input | 1 | Watchdog feed pulse |
| ext_fault_i | input | 1 | Recoverable fault pulse from elsewhere |
| degrade_i | input | 1 | Request for reduced-limit operation |
| svc_clear_i | input | 1 | Explicit service clear |
| bo_warn_i | input | 1 | Supply warning comparator |
| bo_reset_i | input | 1 | Supply reset comparator |
| state_o | output | 3 | Supervisor state code |
| safe_req_o | output | 1 | Request safe output value |
| sys_reset_o | output | 1 | Reset request |
| degraded_o | output | 1 | Reduced limits in force |
| retry_cnt_o | output | clog2(MAX_RETRY+1) | Faults since last accepted feed |
| evt_seq_o | output | SEQ_W | Sequence number of last record |
| evt_cause_o | output | 4 | Cause code of last record |
| evt_ts_o | output | TS_W | Timestamp of last record |
| evt_commit_o | output | 1 | Record just written |
| dl_miss_cnt_o | output | CNT_W | Deadline-miss count |
| hb_miss_cnt_o | output | CNT_W | Heartbeat-miss count |

## Verification
On every cycle the assertions hold the state rules that relate one cycle to the next: the latched state only opens on a service clear, backoff only leads back to running, the reset input always yields a reset request, escalation only happens from a full retry count, and the sequence number and miss counters never move backwards. Whether a given feed is early, late, unhealthy or accepted depends on how many cycles and which strobes preceded it, so the cause codes, the exact backoff length, the return to degraded operation and sequence saturation are shown by the bench's scenarios, with each record matched against a queue of expected causes.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DEGR    = 3'd1,
    ST_BACKOFF = 3'd2,
    ST_LATCH   = 3'd3,
    ST_WARN    = 3'd4,
    ST_RST     = 3'd5
  } sup_state_e;

  typedef enum logic [3:0] {
    CA_NONE      = 4'd0,
    CA_WD_EARLY  = 4'd1,
    CA_WD_LATE   = 4'd2,
    CA_WD_UNHLTH = 4'd3,
    CA_EXT       = 4'd4,
    CA_ESCALATE  = 4'd5,
    CA_DEGRADE   = 4'd6,
    CA_BO_WARN   = 4'd7,
    CA_BO_RESET  = 4'd8,
    CA_SVC_CLEAR = 4'd9
  } cause_e;

  // One-hot-or-zero outcome of a watchdog window.
  typedef struct packed {
    logic ok;
    logic early;
    logic late;
    logic unhealthy;
  } wd_verdict_t;

endpackage

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int WIN_OPEN  = 64,
  parameter int WIN_CLOSE = 256,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             heartbeat,
  input  logic             deadline_miss,
  input  logic             sample_stb,
  input  logic             update_stb,
  input  logic             feed,
  output wd_verdict_t      verdict,
  output logic [CNT_W-1:0] dl_miss_cnt,
  output logic [CNT_W-1:0] hb_miss_cnt
);

  localparam int WC_W = $clog2(WIN_CLOSE + 1);
  localparam logic [WC_W-1:0]  OPEN_V  = WC_W'(WIN_OPEN);
  localparam logic [WC_W-1:0]  CLOSE_V = WC_W'(WIN_CLOSE);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WC_W-1:0] cnt_q;
  logic hb_q, smp_q, upd_q, dl_q;
  logic hb_any, healthy, win_end;

  // Evidence includes pulses in the cycle of the feed itself.
  assign hb_any  = hb_q | heartbeat;
  assign healthy = hb_any & (smp_q | sample_stb) & (upd_q | update_stb)
                 & ~(dl_q | deadline_miss);

  always_comb begin
    verdict = '0;
    if (en) begin
      if (cnt_q >= CLOSE_V)     verdict.late      = 1'b1;
      else if (feed) begin
        if (cnt_q < OPEN_V)     verdict.early     = 1'b1;
        else if (healthy)       verdict.ok        = 1'b1;
        else                    verdict.unhealthy = 1'b1;
      end
    end
  end

  assign win_end = verdict.ok | verdict.early | verdict.late | verdict.unhealthy;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || win_end) begin
      cnt_q <= '0;
      hb_q  <= 1'b0;
      smp_q <= 1'b0;
      upd_q <= 1'b0;
      dl_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      hb_q  <= hb_q  | heartbeat;
      smp_q <= smp_q | sample_stb;
      upd_q <= upd_q | update_stb;
      dl_q  <= dl_q  | deadline_miss;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_miss_cnt <= '0;
      hb_miss_cnt <= '0;
    end else begin
      if (deadline_miss && dl_miss_cnt != CNT_MAX)
        dl_miss_cnt <= dl_miss_cnt + 1'b1;
      if (win_end && !hb_any && hb_miss_cnt != CNT_MAX)
        hb_miss_cnt <= hb_miss_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
#(
  parameter int BACKOFF_CYC = 128,
  parameter int MAX_RETRY   = 3,
  localparam int RT_W       = $clog2(MAX_RETRY + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wd_verdict_t     verdict,
  input  logic            ext_fault,
  input  logic            degrade_req,
  input  logic            svc_clear,
  input  logic            bo_warn,
  input  logic            bo_reset,
  output sup_state_e      state,
  output logic [RT_W-1:0] retry_cnt,
  output logic            degraded,
  output logic            log_en,
  output cause_e          log_cause
);

  localparam int BO_W = $clog2(BACKOFF_CYC + 1);
  localparam logic [BO_W-1:0] BO_LAST = BO_W'(BACKOFF_CYC - 1);
  localparam logic [RT_W-1:0] RT_MAX  = RT_W'(MAX_RETRY);

  sup_state_e      state_q, state_d;
  logic [BO_W-1:0] boc_q, boc_d;
  logic [RT_W-1:0] retry_q, retry_d;
  logic            degr_q, degr_d;
  logic            wd_fault;
  sup_state_e      resume;

  assign wd_fault = verdict.early | verdict.late | verdict.unhealthy;
  assign resume   = degr_q ? ST_DEGR : ST_RUN;

  always_comb begin
    state_d   = state_q;
    boc_d     = boc_q;
    retry_d   = retry_q;
    degr_d    = degr_q;
    log_en    = 1'b0;
    log_cause = CA_NONE;
    if (bo_reset) begin
      if (state_q != ST_RST) begin
        log_en    = 1'b1;
        log_cause = CA_BO_RESET;
      end
      state_d = ST_RST;
      boc_d   = '0;
      retry_d = '0;
      degr_d  = 1'b0;
    end else if (state_q == ST_RST) begin
      state_d = ST_BACKOFF;
      boc_d   = '0;
    end else if (bo_warn && state_q != ST_LATCH) begin
      if (state_q != ST_WARN) begin
        log_en    = 1'b1;
        log_cause = CA_BO_WARN;
      end
      state_d = ST_WARN;
    end else begin
      case (state_q)
        ST_WARN: begin
          state_d = ST_BACKOFF;
          boc_d   = '0;
        end
        ST_RUN, ST_DEGR: begin
          if (verdict.ok) retry_d = '0;
          if (wd_fault || ext_fault) begin
            log_en = 1'b1;
            if (retry_q >= RT_MAX) begin
              state_d   = ST_LATCH;
              log_cause = CA_ESCALATE;
            end else begin
              state_d   = ST_BACKOFF;
              boc_d     = '0;
              retry_d   = retry_q + 1'b1;
              log_cause = verdict.early     ? CA_WD_EARLY  :
                          verdict.late      ? CA_WD_LATE   :
                          verdict.unhealthy ? CA_WD_UNHLTH : CA_EXT;
            end
          end else if (degrade_req && state_q == ST_RUN) begin
            state_d   = ST_DEGR;
            degr_d    = 1'b1;
            log_en    = 1'b1;
            log_cause = CA_DEGRADE;
          end
        end
        ST_BACKOFF: begin
          if (boc_q == BO_LAST) state_d = resume;
          else                  boc_d   = boc_q + 1'b1;
        end
        ST_LATCH: begin
          if (svc_clear) begin
            state_d   = ST_RUN;
            retry_d   = '0;
            degr_d    = 1'b0;
            log_en    = 1'b1;
            log_cause = CA_SVC_CLEAR;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      boc_q   <= '0;
      retry_q <= '0;
      degr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      boc_q   <= boc_d;
      retry_q <= retry_d;
      degr_q  <= degr_d;
    end
  end

  assign state     = state_q;
  assign retry_cnt = retry_q;
  assign degraded  = degr_q;

endmodule

// File: rtl/sup_evlog.sv
module sup_evlog
  import sup_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             log_en,
  input  cause_e           cause,
  output logic [SEQ_W-1:0] seq,
  output logic [3:0]       cause_rec,
  output logic [TS_W-1:0]  ts_rec,
  output logic             commit
);

  localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};

  logic [TS_W-1:0] tbase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbase_q   <= '0;
      seq       <= '0;
      cause_rec <= CA_NONE;
      ts_rec    <= '0;
      commit    <= 1'b0;
    end else begin
      tbase_q <= tbase_q + 1'b1;
      commit  <= log_en;
      if (log_en) begin
        if (seq != SEQ_MAX) seq <= seq + 1'b1;
        cause_rec <= cause;
        ts_rec    <= tbase_q;
      end
    end
  end

endmodule

// File: rtl/loop_supervisor.sv
module loop_supervisor
  import sup_pkg::*;
#(
  parameter int WIN_OPEN    = 64,
  parameter int WIN_CLOSE   = 256,
  parameter int BACKOFF_CYC = 128,
  parameter int MAX_RETRY   = 3,
  parameter int SEQ_W       = 16,
  parameter int TS_W        = 32,
  parameter int CNT_W       = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             heartbeat_i,
  input  logic                             deadline_miss_i,
  input  logic                             sample_stb_i,
  input  logic                             update_stb_i,
  input  logic                             feed_i,
  input  logic                             ext_fault_i,
  input  logic                             degrade_i,
  input  logic                             svc_clear_i,
  input  logic                             bo_warn_i,
  input  logic                             bo_reset_i,
  output logic [2:0]                       state_o,
  output logic                             safe_req_o,
  output logic                             sys_reset_o,
  output logic                             degraded_o,
  output logic [$clog2(MAX_RETRY+1)-1:0]   retry_cnt_o,
  output logic [SEQ_W-1:0]                 evt_seq_o,
  output logic [3:0]                       evt_cause_o,
  output logic [TS_W-1:0]                  evt_ts_o,
  output logic                             evt_commit_o,
  output logic [CNT_W-1:0]                 dl_miss_cnt_o,
  output logic [CNT_W-1:0]                 hb_miss_cnt_o
);

  wd_verdict_t verdict;
  sup_state_e  state;
  logic        wd_en;
  logic        log_en;
  cause_e      log_cause;

  assign wd_en = (state == ST_RUN) || (state == ST_DEGR);

  sup_wdog #(
    .WIN_OPEN (WIN_OPEN),
    .WIN_CLOSE(WIN_CLOSE),
    .CNT_W    (CNT_W)
  ) u_wdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (wd_en),
    .heartbeat    (heartbeat_i),
    .deadline_miss(deadline_miss_i),
    .sample_stb   (sample_stb_i),
    .update_stb   (update_stb_i),
    .feed         (feed_i),
    .verdict      (verdict),
    .dl_miss_cnt  (dl_miss_cnt_o),
    .hb_miss_cnt  (hb_miss_cnt_o)
  );

  sup_fsm #(
    .BACKOFF_CYC(BACKOFF_CYC),
    .MAX_RETRY  (MAX_RETRY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .verdict    (verdict),
    .ext_fault  (ext_fault_i),
    .degrade_req(degrade_i),
    .svc_clear  (svc_clear_i),
    .bo_warn    (bo_warn_i),
    .bo_reset   (bo_reset_i),
    .state      (state),
    .retry_cnt  (retry_cnt_o),
    .degraded   (degraded_o),
    .log_en     (log_en),
    .log_cause  (log_cause)
  );

  sup_evlog #(
    .SEQ_W(SEQ_W),
    .TS_W (TS_W)
  ) u_evlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .log_en   (log_en),
    .cause    (log_cause),
    .seq      (evt_seq_o),
    .cause_rec(evt_cause_o),
    .ts_rec   (evt_ts_o),
    .commit   (evt_commit_o)
  );

  assign state_o     = state;
  assign safe_req_o  = (state == ST_WARN) || (state == ST_BACKOFF) ||
                       (state == ST_LATCH) || (state == ST_RST);
  assign sys_reset_o = (state == ST_RST);

endmodule

// File: rtl/sup_checker.sv
module sup_checker
  import sup_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16,
  localparam int RT_W     = $clog2(MAX_RETRY + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bo_warn_i,
  input logic             bo_reset_i,
  input logic             svc_clear_i,
  input logic [2:0]       state_o,
  input logic             safe_req_o,
  input logic             sys_reset_o,
  input logic [RT_W-1:0]  retry_cnt_o,
  input logic [SEQ_W-1:0] evt_seq_o,
  input logic [3:0]       evt_cause_o,
  input logic             evt_commit_o,
  input logic [CNT_W-1:0] dl_miss_cnt_o,
  input logic [CNT_W-1:0] hb_miss_cnt_o
);

  assert_backoff_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_BACKOFF && !bo_warn_i && !bo_reset_i) |=>
      (state_o == ST_BACKOFF || state_o == ST_RUN || state_o == ST_DEGR));

  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_LATCH && !svc_clear_i && !bo_reset_i) |=>
      (state_o == ST_LATCH && safe_req_o));

  assert_escalate_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_LATCH && $past(state_o) != ST_LATCH) |->
      ($past(retry_cnt_o) == RT_W'(MAX_RETRY)));

  assert_warn_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_warn_i && !bo_reset_i && state_o != ST_LATCH) |=> safe_req_o);

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bo_reset_i |=> (sys_reset_o && retry_cnt_o == '0));

  assert_seq_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_seq_o >= $past(evt_seq_o)));

  assert_commit_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit_o |-> (evt_cause_o != CA_NONE));

  assert_miss_counts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dl_miss_cnt_o >= $past(dl_miss_cnt_o) &&
              hb_miss_cnt_o >= $past(hb_miss_cnt_o)));

endmodule

bind loop_supervisor sup_checker #(
  .MAX_RETRY(MAX_RETRY),
  .SEQ_W    (SEQ_W),
  .CNT_W    (CNT_W)
) u_sup_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bo_warn_i    (bo_warn_i),
  .bo_reset_i   (bo_reset_i),
  .svc_clear_i  (svc_clear_i),
  .state_o      (state_o),
  .safe_req_o   (safe_req_o),
  .sys_reset_o  (sys_reset_o),
  .retry_cnt_o  (retry_cnt_o),
  .evt_seq_o    (evt_seq_o),
  .evt_cause_o  (evt_cause_o),
  .evt_commit_o (evt_commit_o),
  .dl_miss_cnt_o(dl_miss_cnt_o),
  .hb_miss_cnt_o(hb_miss_cnt_o)
);

// File: tb/loop_supervisor_tb_top.sv
`timescale 1ns/1ps
module loop_supervisor_tb_top;

  localparam int WOPEN = 8;
  localparam int WCLOSE = 16;
  localparam int BOFF = 10;
  localparam int MRET = 2;
  localparam int SW = 4;
  localparam int TW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic heartbeat_i = 0, deadline_miss_i = 0, sample_stb_i = 0, update_stb_i = 0;
  logic feed_i = 0, ext_fault_i = 0, degrade_i = 0, svc_clear_i = 0;
  logic bo_warn_i = 0, bo_reset_i = 0;
  logic [2:0] state_o;
  logic safe_req_o, sys_reset_o, degraded_o, evt_commit_o;
  logic [1:0] retry_cnt_o;
  logic [SW-1:0] evt_seq_o;
  logic [3:0] evt_cause_o;
  logic [TW-1:0] evt_ts_o;
  logic [CW-1:0] dl_miss_cnt_o, hb_miss_cnt_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  int exp_seq = 0;
  logic [TW-1:0] last_ts = '0;
  logic seen_ts = 1'b0;

  always #2 clk = ~clk;

  loop_supervisor #(
    .WIN_OPEN(WOPEN), .WIN_CLOSE(WCLOSE), .BACKOFF_CYC(BOFF),
    .MAX_RETRY(MRET), .SEQ_W(SW), .TS_W(TW), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .heartbeat_i(heartbeat_i),
    .deadline_miss_i(deadline_miss_i), .sample_stb_i(sample_stb_i),
    .update_stb_i(update_stb_i), .feed_i(feed_i), .ext_fault_i(ext_fault_i),
    .degrade_i(degrade_i), .svc_clear_i(svc_clear_i), .bo_warn_i(bo_warn_i),
    .bo_reset_i(bo_reset_i), .state_o(state_o), .safe_req_o(safe_req_o),
    .sys_reset_o(sys_reset_o), .degraded_o(degraded_o),
    .retry_cnt_o(retry_cnt_o), .evt_seq_o(evt_seq_o),
    .evt_cause_o(evt_cause_o), .evt_ts_o(evt_ts_o),
    .evt_commit_o(evt_commit_o), .dl_miss_cnt_o(dl_miss_cnt_o),
    .hb_miss_cnt_o(hb_miss_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: expected record causes.
  task automatic expect_evt(input logic [3:0] c);
    exp_q.push_back(c);
  endtask

  task automatic wait_state(input string req, input int st);
    for (int i = 0; i < 100; i++) begin
      if (int'(state_o) == st) return;
      step(1);
    end
    chk(req, int'(state_o), st);
  endtask

  task automatic healthy_window();
    heartbeat_i = 1; sample_stb_i = 1; update_stb_i = 1;
    step(1);
    heartbeat_i = 0; sample_stb_i = 0; update_stb_i = 0;
    step(8);
    feed_i = 1; step(1); feed_i = 0;
  endtask

  task automatic pulse_ext();
    ext_fault_i = 1; step(1); ext_fault_i = 0;
  endtask

  // Monitor side: every committed record must match the queue head (R10).
  always @(negedge clk) begin
    if (rst_n && evt_commit_o) begin
      checks++;
      exp_seq = (exp_seq == 15) ? 15 : exp_seq + 1;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected record cause %0d expected none", evt_cause_o);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if (evt_cause_o !== e || int'(evt_seq_o) != exp_seq ||
            (seen_ts && evt_ts_o <= last_ts)) begin
          fails++;
          $display("FAIL R10: cause %0d seq %0d ts %0d expected cause %0d seq %0d ts above %0d",
                   evt_cause_o, evt_seq_o, evt_ts_o, e, exp_seq, last_ts);
        end
      end
      last_ts = evt_ts_o;
      seen_ts = 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    chk("reset state", int'(state_o), 0);
    chk("reset safe_req", int'(safe_req_o), 0);
    chk("reset seq", int'(evt_seq_o), 0);
    chk("reset R11 hb count", int'(hb_miss_cnt_o), 0);

    // R1: accepted feeds leave everything unchanged.
    healthy_window();
    healthy_window();
    chk("R1 state after good feeds", int'(state_o), 0);
    chk("R1 no safe_req", int'(safe_req_o), 0);

    // R2: early feed, then R5 backoff length and ignored fault.
    step(2);
    expect_evt(4'd1);
    feed_i = 1; step(1); feed_i = 0;
    chk("R2 early -> backoff", int'(state_o), 2);
    chk("R5 safe_req in backoff", int'(safe_req_o), 1);
    chk("R5 retry raised", int'(retry_cnt_o), 1);
    chk("R11 hb miss on early", int'(hb_miss_cnt_o), 1);
    step(4);
    pulse_ext();
    chk("R5 fault ignored in backoff", int'(state_o), 2);
    step(4);
    chk("R5 still backoff at cycle 9", int'(state_o), 2);
    step(1);
    chk("R5 resume after BACKOFF_CYC", int'(state_o), 0);

    // R4: missing sample strobe.
    heartbeat_i = 1; update_stb_i = 1; step(1);
    heartbeat_i = 0; update_stb_i = 0;
    step(8);
    expect_evt(4'd3);
    feed_i = 1; step(1); feed_i = 0;
    chk("R4 unhealthy -> backoff", int'(state_o), 2);
    chk("R4 retry 2", int'(retry_cnt_o), 2);
    wait_state("R5 return", 0);

    // R12: good feed clears retry.
    healthy_window();
    chk("R12 retry cleared", int'(retry_cnt_o), 0);

    // R4/R11: deadline miss spoils otherwise good evidence.
    heartbeat_i = 1; sample_stb_i = 1; update_stb_i = 1; deadline_miss_i = 1;
    step(1);
    heartbeat_i = 0; sample_stb_i = 0; update_stb_i = 0; deadline_miss_i = 0;
    step(8);
    expect_evt(4'd3);
    feed_i = 1; step(1); feed_i = 0;
    chk("R4 deadline -> unhealthy", int'(state_o), 2);
    chk("R11 dl count", int'(dl_miss_cnt_o), 1);
    wait_state("R5 return", 0);

    // R3: no feed at all.
    expect_evt(4'd2);
    step(16);
    chk("R3 before close", int'(state_o), 0);
    step(1);
    chk("R3 late -> backoff", int'(state_o), 2);
    chk("R3 retry 2", int'(retry_cnt_o), 2);
    chk("R11 hb miss on late", int'(hb_miss_cnt_o), 2);
    wait_state("R5 return", 0);

    // R6: escalation to latch.
    expect_evt(4'd5);
    pulse_ext();
    chk("R6 latched", int'(state_o), 3);
    chk("R6 safe_req", int'(safe_req_o), 1);
    pulse_ext();
    bo_warn_i = 1; step(3); bo_warn_i = 0;
    step(20);
    chk("R6 R8 latch ignores fault and warn", int'(state_o), 3);
    expect_evt(4'd9);
    svc_clear_i = 1; step(1); svc_clear_i = 0;
    chk("R6 service clear -> run", int'(state_o), 0);
    chk("R6 retry zero", int'(retry_cnt_o), 0);

    // R7: degraded mode.
    expect_evt(4'd6);
    degrade_i = 1; step(1); degrade_i = 0;
    chk("R7 degraded state", int'(state_o), 1);
    chk("R7 degraded flag", int'(degraded_o), 1);
    chk("R7 no safe_req", int'(safe_req_o), 0);
    healthy_window();
    chk("R7 watchdog runs in degraded", int'(state_o), 1);
    expect_evt(4'd4);
    pulse_ext();
    chk("R4 ext fault -> backoff", int'(state_o), 2);
    wait_state("R7 return to degraded", 1);
    healthy_window();

    // R8: warning entry and release.
    expect_evt(4'd7);
    bo_warn_i = 1; step(1);
    chk("R8 warn state", int'(state_o), 4);
    chk("R8 safe_req", int'(safe_req_o), 1);
    step(4);
    chk("R8 still warn", int'(state_o), 4);
    bo_warn_i = 0; step(1);
    chk("R8 release -> backoff", int'(state_o), 2);
    chk("R8 retry unchanged", int'(retry_cnt_o), 0);
    wait_state("R8 return", 1);
    healthy_window();

    // R9: reset wins over warn and clears degraded.
    expect_evt(4'd8);
    bo_warn_i = 1; bo_reset_i = 1; step(1);
    chk("R9 reset state", int'(state_o), 5);
    chk("R9 sys_reset", int'(sys_reset_o), 1);
    step(2);
    bo_warn_i = 0; bo_reset_i = 0; step(1);
    chk("R9 release -> backoff", int'(state_o), 2);
    chk("R9 sys_reset low", int'(sys_reset_o), 0);
    chk("R9 degraded cleared", int'(degraded_o), 0);
    wait_state("R9 return", 0);

    // R10: drive the sequence number into saturation.
    for (int r = 0; r < 2; r++) begin
      expect_evt(4'd4); pulse_ext(); wait_state("R10 round", 0);
      expect_evt(4'd4); pulse_ext(); wait_state("R10 round", 0);
      expect_evt(4'd5); pulse_ext();
      expect_evt(4'd9); svc_clear_i = 1; step(1); svc_clear_i = 0;
    end
    step(2);
    chk("R10 seq saturates", int'(evt_seq_o), 15);
    chk("R10 all records seen", exp_q.size(), 0);
    chk("R11 hb count final", int'(hb_miss_cnt_o), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule